// File: doc/BRIEF.md
# Indirectly indexed per-core timer bank

This peripheral keeps one free-running 64-bit counter per processor core. The counters feed the cores' system-time logic, so they must all advance together and stay at zero until they are started. A single shared enable starts every counter in the same cycle. A prescaler, chosen by a one-hot field, turns the input clock into a tick pulse. Each counter advances by one on every tick.

The bus sees only two 32-bit registers. Software writes an internal register number to the index register, then reads or writes the data register to reach that internal register. The internal space holds:

- a global control word (enable and prescaler choice);
- one interrupt enable bit per core;
- the count words, which are read-only;
- one 32-bit compare value per core.

Each core has a level interrupt output. It is high while that core's interrupt enable is set and the low word of its count has reached its compare value. Masking an interrupt never affects the counter.

Top module: `core_timer_bank`

## Requirements
- R1: The bus window decodes `bus_addr` with bits 1:0 equal to 0. Address 0x4 is the index register: an 8-bit value, written from `bus_wdata[7:0]`, that reads back zero-extended. Address 0x0 is the data register and reaches the internal register currently named by the index. A read strobe at a clock edge places the result on `bus_rdata` after that edge, and the value holds until the next read.
- R2: Internal index 0x00 is global control. Bit 0 is the enable and bits 10:8 are the prescaler field. It reads back exactly those bits; all other bits read zero.
- R3: While the enable is clear, every counter is zero within one cycle, and count reads return zero.
- R4: While the enable is set, all counters advance together. After an enable write captured at edge e, with division N, each count equals floor((m-e)/N) after edge m.
- R5: The prescaler field selects the division. The value 3'b001 divides by 1, 3'b010 by 2 and 3'b100 by 4. Any other value, including zero and values with more than one bit set, divides by 1.
- R6: For core n, index 0x10+8n reads the low count word and index 0x14+8n reads the high word. Reading the low word latches the high word, and the high-word index returns that latched copy. Writes to count indices have no effect.
- R7: Internal index 0x30 holds the interrupt enables: bit n is core n's enable, and the other bits read zero.
- R8: Index 0x40+4n is core n's 32-bit compare register, readable and writable. `irq_o[n]` is high exactly when enable bit n is set and the low count word is greater than or equal to compare n.
- R9: Clearing interrupt enables does not stop or disturb any counter.
- R10: Any other internal index reads as zero, and writes to it change no register.
- R11: After reset, the index register, control, interrupt enables, compare values, latched high words, `bus_rdata`, `irq_o` and `time_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the bus window |
| bus_rd | input | 1 | Read strobe for the bus window |
| bus_addr | input | 3 | Byte offset in the window (0x0 data, 0x4 index) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_CORES | Per-core compare-match interrupt level |
| time_o | output | NUM_CORES*64 | Per-core count, core n in bits 64n+63:64n |

## Verification
The assertions check several behaviours on every cycle:

- Counters are held at zero while the bank is disabled.
- Each counter advances by exactly one per tick and holds between ticks.
- All cores stay equal.
- Ticks are spaced correctly for the divide-by-2 and divide-by-4 settings.
- Writes to the index register are captured.
- The high word is latched on a low-word read.
- Unimplemented indices never change state.
- Interrupts stay quiet when all enables are clear.

Some behaviours only the bench's scenarios can show. These are the absolute count value after enabling under each prescaler code, including the illegal codes that fall back to divide by 1. They also include control readback with junk bits, the interrupt edge as the count reaches a compare value, and counting that goes on after masking.

// File: rtl/tbank_pkg.sv
package tbank_pkg;

    localparam int IDX_W = 8;

    localparam logic [IDX_W-1:0] IDX_CTRL     = 8'h00;
    localparam logic [IDX_W-1:0] IDX_CNT_BASE = 8'h10;
    localparam logic [IDX_W-1:0] IDX_IRQEN    = 8'h30;
    localparam logic [IDX_W-1:0] IDX_CMP_BASE = 8'h40;

    typedef enum logic [1:0] {
        DIV_BY1 = 2'd0,
        DIV_BY2 = 2'd1,
        DIV_BY4 = 2'd2
    } div_e;

    // Prescaler field is one-hot; anything else falls back to divide by 1.
    function automatic div_e decode_div(input logic [2:0] fld);
        case (fld)
            3'b010:  return DIV_BY2;
            3'b100:  return DIV_BY4;
            default: return DIV_BY1;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] cnt_lo_idx(input int n);
        return IDX_CNT_BASE + IDX_W'(8 * n);
    endfunction

    function automatic logic [IDX_W-1:0] cnt_hi_idx(input int n);
        return IDX_CNT_BASE + IDX_W'(8 * n + 4);
    endfunction

    function automatic logic [IDX_W-1:0] cmp_idx(input int n);
        return IDX_CMP_BASE + IDX_W'(4 * n);
    endfunction

endpackage

// File: rtl/tbank_presc.sv
module tbank_presc
    import tbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  div_e div,
    output logic tick
);

    logic [1:0] pcnt_d, pcnt_q;
    logic [1:0] limit;

    always_comb begin
        case (div)
            DIV_BY2: limit = 2'd1;
            DIV_BY4: limit = 2'd3;
            default: limit = 2'd0;
        endcase
        tick = run && (pcnt_q >= limit);
        if (!run || tick) pcnt_d = '0;
        else              pcnt_d = pcnt_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R5: a tick at divide by 2 or 4 is never followed by another at once
    a_r5_div2_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div == DIV_BY2 && tick) |=> (!tick || div != $past(div)));
    a_r5_div4_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div == DIV_BY4 && tick) |=> (!tick || div != $past(div)));

endmodule

// File: rtl/tbank_core.sv
module tbank_core #(
    parameter int CNT_W = 64,
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             irq_en,
    input  logic [CMP_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
    assign irq_o = irq_en && (cnt_q[CMP_W-1:0] >= cmp);

    // R3: a disabled bank leaves the counter at zero one cycle later
    a_r3_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
    // R4: exactly one step per tick
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    // R4: no movement between ticks
    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/core_timer_bank.sv
module core_timer_bank
    import tbank_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 64,
    parameter int DW        = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [2:0]                 bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    output logic [DW-1:0]              bus_rdata,
    output logic [NUM_CORES-1:0]       irq_o,
    output logic [NUM_CORES*CNT_W-1:0] time_o
);

    localparam int DIV_LSB = 8;

    typedef struct packed {
        logic [IDX_W-1:0]               idx;
        logic                           en;
        logic [2:0]                     div;
        logic [NUM_CORES-1:0]           ie;
        logic [NUM_CORES-1:0][DW-1:0]   cmp;
        logic [NUM_CORES-1:0][DW-1:0]   hi;
        logic [DW-1:0]                  rdata;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_CORES-1:0][CNT_W-1:0] cnt;
    logic [DW-1:0]                   rd_val;
    logic                            idx_known;
    logic                            win_ok;
    logic                            sel_idx;
    logic                            tick;
    div_e                            div_sel;

    assign win_ok  = (bus_addr[1:0] == 2'b00);
    assign sel_idx = bus_addr[2];
    assign div_sel = decode_div(s_q.div);

    tbank_presc u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.en),
        .div   (div_sel),
        .tick  (tick)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        tbank_core #(
            .CNT_W (CNT_W),
            .CMP_W (DW)
        ) u_core (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (s_q.en),
            .tick   (tick),
            .irq_en (s_q.ie[g]),
            .cmp    (s_q.cmp[g]),
            .cnt_o  (cnt[g]),
            .irq_o  (irq_o[g])
        );
        assign time_o[g*CNT_W +: CNT_W] = cnt[g];
    end

    always_comb begin
        s_d       = s_q;
        rd_val    = '0;
        idx_known = 1'b0;

        // internal read multiplexer
        if (s_q.idx == IDX_CTRL) begin
            rd_val    = DW'({s_q.div, 7'b0, s_q.en});
            idx_known = 1'b1;
        end
        if (s_q.idx == IDX_IRQEN) begin
            rd_val    = DW'(s_q.ie);
            idx_known = 1'b1;
        end
        for (int n = 0; n < NUM_CORES; n++) begin
            if (s_q.idx == cnt_lo_idx(n)) begin
                rd_val    = cnt[n][DW-1:0];
                idx_known = 1'b1;
            end
            if (s_q.idx == cnt_hi_idx(n)) begin
                rd_val    = s_q.hi[n];
                idx_known = 1'b1;
            end
            if (s_q.idx == cmp_idx(n)) begin
                rd_val    = s_q.cmp[n];
                idx_known = 1'b1;
            end
        end

        // bus reads
        if (bus_rd && win_ok) begin
            if (sel_idx) begin
                s_d.rdata = DW'(s_q.idx);
            end else begin
                s_d.rdata = rd_val;
                for (int n = 0; n < NUM_CORES; n++) begin
                    if (s_q.idx == cnt_lo_idx(n))
                        s_d.hi[n] = cnt[n][CNT_W-1:DW];
                end
            end
        end

        // bus writes
        if (bus_wr && win_ok) begin
            if (sel_idx) begin
                s_d.idx = bus_wdata[IDX_W-1:0];
            end else begin
                if (s_q.idx == IDX_CTRL) begin
                    s_d.en  = bus_wdata[0];
                    s_d.div = bus_wdata[DIV_LSB+2:DIV_LSB];
                end
                if (s_q.idx == IDX_IRQEN)
                    s_d.ie = bus_wdata[NUM_CORES-1:0];
                for (int n = 0; n < NUM_CORES; n++) begin
                    if (s_q.idx == cmp_idx(n))
                        s_d.cmp[n] = bus_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;

    // R1: an index write lands in the index register
    a_r1_idx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win_ok && sel_idx) |=> (s_q.idx == $past(bus_wdata[IDX_W-1:0])));

    // R6: reading the low word of core 0 latches its high word
    a_r6_hi_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && win_ok && !sel_idx && s_q.idx == cnt_lo_idx(0))
        |=> (s_q.hi[0] == $past(cnt[0][CNT_W-1:DW])));

    // R10: writes to unimplemented indices leave all state untouched
    a_r10_unimpl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win_ok && !sel_idx && !idx_known)
        |=> ($stable(s_q.en) && $stable(s_q.div) && $stable(s_q.ie) && $stable(s_q.cmp)));

    // R7: no interrupt while every enable is clear
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ie == '0) |-> (irq_o == '0));

    // R4: every core equals core 0 on every cycle
    for (genvar g = 1; g < NUM_CORES; g++) begin : g_lock
        a_r4_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] == cnt[0]);
    end

endmodule

// File: tb/tb_core_timer_bank.sv
module tb_core_timer_bank;

    localparam int NC = 4;
    localparam int CW = 64;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [NC-1:0]     irq_o;
    logic [NC*CW-1:0]  time_o;

    core_timer_bank #(.NUM_CORES(NC), .CNT_W(CW), .DW(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .time_o    (time_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    bit          running = 1'b0;
    int unsigned en_edge = 0;
    int unsigned ratio = 1;

    // scoreboard
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          rd_cap = 1'b0;

    task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_cap <= bus_rd;

    always @(negedge clk) begin : monitor
        logic [DW-1:0] ev;
        string et;
        if (rd_cap) begin
            if (exp_q.size() == 0) begin
                check("R1 read with no expectation", 64'(bus_rdata), 64'hx);
            end else begin
                ev = exp_q.pop_front();
                et = tag_q.pop_front();
                check(et, 64'(bus_rdata), 64'(ev));
            end
        end
    end

    function automatic logic [CW-1:0] model_cnt();
        if (!running) return '0;
        return CW'((cyc - en_edge) / ratio);
    endfunction

    task automatic bus_cycle(logic wr, logic rd, logic [2:0] a, logic [DW-1:0] d);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic reg_wr(logic [7:0] idx, logic [DW-1:0] v);
        bus_cycle(1'b1, 1'b0, 3'h4, DW'(idx));
        bus_cycle(1'b1, 1'b0, 3'h0, v);
    endtask

    task automatic reg_rd(logic [7:0] idx, logic [DW-1:0] e, string tag);
        bus_cycle(1'b1, 1'b0, 3'h4, DW'(idx));
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_cycle(1'b0, 1'b1, 3'h0, '0);
    endtask

    task automatic cnt_rd(int core, string tag);
        bus_cycle(1'b1, 1'b0, 3'h4, DW'(8'h10 + 8 * core));
        exp_q.push_back(model_cnt()); tag_q.push_back(tag);
        bus_cycle(1'b0, 1'b1, 3'h0, '0);
    endtask

    task automatic set_ctrl(logic [DW-1:0] v);
        bus_cycle(1'b1, 1'b0, 3'h4, '0);
        if (v[0] && !running) en_edge = cyc + 1;
        running = v[0];
        case (v[10:8])
            3'b010:  ratio = 2;
            3'b100:  ratio = 4;
            default: ratio = 1;
        endcase
        bus_cycle(1'b1, 1'b0, 3'h0, v);
    endtask

    task automatic check_time(string tag);
        check(tag, time_o[CW-1:0], model_cnt());
        for (int c = 1; c < NC; c++)
            check({tag, " lockstep"}, time_o[c*CW +: CW], time_o[CW-1:0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 rdata after reset", 64'(bus_rdata), 0);
        check("R11 irq after reset", 64'(irq_o), 0);
        check("R11 time after reset", time_o[CW-1:0], 0);
        exp_q.push_back(0); tag_q.push_back("R1 R11 index reads zero");
        bus_cycle(1'b0, 1'b1, 3'h4, '0);
        reg_rd(8'h00, 0, "R11 ctrl reset");
        reg_rd(8'h44, 0, "R11 compare reset");

        // R1 index register readback
        bus_cycle(1'b1, 1'b0, 3'h4, 32'hFFFF_FF5A);
        exp_q.push_back(32'h5A); tag_q.push_back("R1 index readback");
        bus_cycle(1'b0, 1'b1, 3'h4, '0);

        // R3 disabled counters stay zero
        repeat (10) @(negedge clk);
        cnt_rd(0, "R3 count zero while disabled");
        cnt_rd(3, "R3 count zero while disabled core3");

        // R2 junk bits dropped, field kept
        set_ctrl(32'hFFFF_FFFE);
        reg_rd(8'h00, 32'h0000_0700, "R2 ctrl readback");

        // R4 R5 under each prescaler code
        begin
            logic [DW-1:0] codes[5] = '{32'h101, 32'h201, 32'h401, 32'h001, 32'h301};
            for (int k = 0; k < 5; k++) begin
                set_ctrl(0);
                repeat (2) @(negedge clk);
                set_ctrl(codes[k]);
                repeat (7 + k) @(negedge clk);
                check_time($sformatf("R4 R5 time code %h", codes[k]));
                cnt_rd(0, $sformatf("R5 count core0 code %h", codes[k]));
                cnt_rd(2, $sformatf("R4 count core2 code %h", codes[k]));
                repeat (5) @(negedge clk);
                check_time($sformatf("R5 time later code %h", codes[k]));
            end
        end
        reg_rd(8'h00, 32'h0000_0301, "R2 ctrl readback enabled");

        // R6 count words and write protection
        set_ctrl(0);
        set_ctrl(32'h201);
        repeat (9) @(negedge clk);
        cnt_rd(1, "R6 low word core1");
        reg_rd(8'h1C, 0, "R6 latched high word core1");
        reg_wr(8'h10, 32'hDEAD_BEEF);
        cnt_rd(0, "R6 write to count ignored");
        check_time("R6 time after count write");

        // R7 R8 interrupts
        reg_wr(8'h48, 32'hFFFF_FFFF);
        reg_rd(8'h48, 32'hFFFF_FFFF, "R8 compare readback");
        reg_wr(8'h30, 32'hFFFF_FFFF);
        reg_rd(8'h30, 32'h0000_000F, "R7 irq enable readback");
        check("R8 irq with core2 compare high", 64'(irq_o), 64'(4'b1011));
        reg_wr(8'h48, 32'd5);
        check("R8 irq after core2 compare lowered", 64'(irq_o), 64'(4'b1111));
        begin
            logic [CW-1:0] target;
            target = model_cnt() + 12;
            reg_wr(8'h44, DW'(target));
            for (int k = 0; k < 40; k++) begin
                check("R8 irq core1 crossing", 64'(irq_o[1]), 64'(model_cnt() >= target));
                @(negedge clk);
            end
        end

        // R9 masking keeps counting
        reg_wr(8'h30, 0);
        check("R7 irq cleared by mask", 64'(irq_o), 0);
        repeat (6) @(negedge clk);
        check_time("R9 counting after mask");
        cnt_rd(3, "R9 count core3 after mask");

        // R10 unimplemented indices
        reg_wr(8'h3C, 32'hFFFF_FFFF);
        reg_wr(8'h08, 32'hFFFF_FFFF);
        reg_rd(8'h3C, 0, "R10 unimplemented read");
        reg_rd(8'hF0, 0, "R10 unimplemented read high");
        reg_rd(8'h00, 32'h0000_0201, "R10 ctrl unchanged");
        reg_rd(8'h30, 0, "R10 irq enable unchanged");
        check_time("R10 time unchanged path");

        // R3 disable clears
        set_ctrl(0);
        @(negedge clk);
        check("R3 time zero after disable", time_o[CW-1:0], 0);
        cnt_rd(2, "R3 count read after disable");

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", 64'(exp_q.size()), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule